// File: doc/BRIEF.md
# Microprogram Sequencer with OR-Form Branching

This block steps through a horizontally coded microprogram. Each microword is wide enough that its control bits drive the datapath with little or no further decoding. The sequencer has no program counter adder. Every microword names the address of its successor in a next-address field. To branch, the sequencer ORs registered condition bits into the low bits of that field. This gives two-way and four-way branches, and a sixteen-way dispatch on an external value.

The microstore sits inside the block and is filled through a plain synchronous write port, normally while reset is held. The store is read combinationally at the next address, and the word read is captured in a pipeline register. The word in that register is the one executing, and its control field appears on `ctrl`. The condition and dispatch inputs are registered on the same edge that loads the pipeline register. A branch therefore tests the values present when the branching word was loaded, not the values present while it executes. This is a one-cycle branch delay. The microcoder must place the targets of a conditional branch so that the low bits that get ORed are zero in the base address. The block does not check this.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, `upc` reads 0 and `ctrl` reads all zeros. The reset value of the pipeline is a no-op word with next address 0 and branch select 0.
- R2: At the first rising edge after reset is released, the word at address 0 starts executing. After that edge, `upc` is 0 and `ctrl` shows the control field of word 0.
- R3: Microword layout: bits [9:0] hold the next address, bits [11:10] hold the branch select, and bits [47:12] hold the control field. When the branch select is 0, the next `upc` equals the next-address field, whatever the values of `cond` and `disp`.
- R4: When the branch select is 1, the next `upc` is the next-address field with its bit 0 ORed with `cond[0]`.
- R5: When the branch select is 2, the next `upc` is the next-address field with its bits [1:0] ORed with `cond[1:0]`.
- R6: When the branch select is 3, the next `upc` is the next-address field with its bits [3:0] ORed with `disp[3:0]`.
- R7: `ctrl` always equals the control field of the stored word at address `upc`.
- R8: The branch decision for the word executing after edge k uses the `cond` and `disp` values sampled at edge k. A change to those inputs during that word's execution has no effect on its successor.
- R9: A write with `wr_en` high stores `wr_data` at `wr_addr`. A later fetch of that address returns the new word.
- R10: There is no increment. A word whose next field equals its own address with branch select 0 executes again every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release must be synchronous to `clk` |
| wr_en | input | 1 | Microstore write strobe |
| wr_addr | input | 10 | Microstore write address |
| wr_data | input | 48 | Microword to be written |
| cond | input | 2 | Status bits used by the two-way and four-way branches |
| disp | input | 4 | Dispatch value used by the sixteen-way branch |
| upc | output | 10 | Address of the executing microword |
| ctrl | output | 36 | Control field of the executing microword |

## Verification
The bench fills all 1024 words with computed microwords. The branch selects are mixed, and each target has its ORed low bits cleared. The sequencer then runs several thousand cycles while `cond` and `disp` change every cycle. Each address and each control field is compared with a model that steps the same rules. Because the inputs change every cycle, a design that tested live inputs instead of the registered ones would branch to the wrong address. A design that ORed the wrong number of bits, or applied a branch under select 0, would leave the expected trace within a few steps. A design that added an increment would fail both the random trace and the self-loop test that follows a rewrite of word 0. The first fetch after each reset is checked on its own, so an extra or missing pipeline stage shows up immediately.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_ONE  = 2'd1,
    BR_TWO  = 2'd2,
    BR_DISP = 2'd3
  } br_sel_e;
endpackage

// File: rtl/ucode_store.sv
module ucode_store #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // write port, clock enable is the strobe
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ucode_branch.sv
module ucode_branch
  import ucode_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DISP_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  br_sel_e           sel,
  input  logic [1:0]        cond_q,
  input  logic [DISP_W-1:0] disp_q,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] or_bits;

  always_comb begin
    or_bits = '0;
    case (sel)
      BR_ONE:  or_bits[0]          = cond_q[0];
      BR_TWO:  or_bits[1:0]        = cond_q;
      BR_DISP: or_bits[DISP_W-1:0] = disp_q;
      default: or_bits             = '0;
    endcase
    nxt = base | or_bits;
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CTRL_W = 36,
  parameter int DISP_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [ADDR_W+2+CTRL_W-1:0] wr_data,
  input  logic [1:0]                 cond,
  input  logic [DISP_W-1:0]          disp,
  output logic [ADDR_W-1:0]          upc,
  output logic [CTRL_W-1:0]          ctrl
);
  localparam int SEL_W    = 2;
  localparam int SEL_LSB  = ADDR_W;
  localparam int CTRL_LSB = ADDR_W + SEL_W;
  localparam int WORD_W   = ADDR_W + SEL_W + CTRL_W;

  logic [WORD_W-1:0] pipe_q, pipe_d, rd_data;
  logic [ADDR_W-1:0] upc_q, upc_d, nxt;
  logic [1:0]        cond_q, cond_d;
  logic [DISP_W-1:0] disp_q, disp_d;
  logic [ADDR_W-1:0] next_f;
  br_sel_e           sel_f;

  assign next_f = pipe_q[ADDR_W-1:0];
  assign sel_f  = br_sel_e'(pipe_q[SEL_LSB +: SEL_W]);

  ucode_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (nxt),
    .rd_data (rd_data)
  );

  ucode_branch #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_branch (
    .base   (next_f),
    .sel    (sel_f),
    .cond_q (cond_q),
    .disp_q (disp_q),
    .nxt    (nxt)
  );

  // next state
  always_comb begin
    pipe_d = rd_data;
    upc_d  = nxt;
    cond_d = cond;
    disp_d = disp;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      upc_q  <= '0;
      cond_q <= '0;
      disp_q <= '0;
    end else begin
      pipe_q <= pipe_d;
      upc_q  <= upc_d;
      cond_q <= cond_d;
      disp_q <= disp_d;
    end
  end

  assign upc  = upc_q;
  assign ctrl = pipe_q[CTRL_LSB +: CTRL_W];

  // assertions
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (upc == '0 && ctrl == '0)
        else $error("reset state wrong");
    end
  end

  assert_unconditional_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q[SEL_LSB +: SEL_W] == 2'd0) |=> (upc == $past(pipe_q[ADDR_W-1:0])))
    else $error("unconditional successor wrong");

  assert_two_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q[SEL_LSB +: SEL_W] == 2'd1 && $past(rst_n)) |=>
    (upc == ($past(pipe_q[ADDR_W-1:0]) | {{(ADDR_W-1){1'b0}}, $past(cond[0], 2)})))
    else $error("two-way branch wrong");

  assert_four_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q[SEL_LSB +: SEL_W] == 2'd2 && $past(rst_n)) |=>
    (upc == ($past(pipe_q[ADDR_W-1:0]) | {{(ADDR_W-2){1'b0}}, $past(cond, 2)})))
    else $error("four-way branch wrong");

  assert_dispatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q[SEL_LSB +: SEL_W] == 2'd3 && $past(rst_n)) |=>
    (upc == ($past(pipe_q[ADDR_W-1:0]) | {{(ADDR_W-DISP_W){1'b0}}, $past(disp, 2)})))
    else $error("dispatch wrong");
endmodule

// File: tb/test_ucode_seq.sv
module test_ucode_seq;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int CTRL_W = 36;
  localparam int DISP_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = ADDR_W + 2 + CTRL_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [1:0]        cond;
  logic [DISP_W-1:0] disp;
  logic [ADDR_W-1:0] upc;
  logic [CTRL_W-1:0] ctrl;

  logic [WORD_W-1:0] img [DEPTH];
  logic [ADDR_W-1:0] m_upc;
  logic [WORD_W-1:0] m_word;
  logic [1:0]        m_cq;
  logic [DISP_W-1:0] m_dq;
  logic [31:0]       lfsr = 32'h1234_5678;
  int checks = 0;
  int fails  = 0;
  bit first_after_reset;

  always #(PERIOD/2) clk = ~clk;

  ucode_seq #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .DISP_W(DISP_W)) i_ucode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cond(cond), .disp(disp), .upc(upc), .ctrl(ctrl)
  );

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [WORD_W-1:0] make_word(int a);
    logic [1:0]        s;
    logic [ADDR_W-1:0] t;
    logic [CTRL_W-1:0] c;
    s = 2'((a * 7 + (a >> 3)) % 4);
    t = ADDR_W'((a * 37 + 11) % DEPTH);
    case (s)
      2'd1: t[0]   = 1'b0;
      2'd2: t[1:0] = 2'b00;
      2'd3: t[3:0] = 4'b0000;
      default: ;
    endcase
    c = CTRL_W'(a * 40503 + 7) ^ (CTRL_W'(a) << 20);
    return {c, s, t};
  endfunction

  function automatic logic [ADDR_W-1:0] succ(logic [WORD_W-1:0] w, logic [1:0] c,
                                             logic [DISP_W-1:0] d);
    logic [ADDR_W-1:0] t;
    t = w[ADDR_W-1:0];
    case (w[ADDR_W +: 2])
      2'd1: t[0]   = t[0] | c[0];
      2'd2: t[1:0] = t[1:0] | c;
      2'd3: t[3:0] = t[3:0] | d;
      default: ;
    endcase
    return t;
  endfunction

  task automatic model_reset();
    m_upc = '0; m_word = '0; m_cq = '0; m_dq = '0;
    first_after_reset = 1'b1;
  endtask

  // called at a negedge with rst_n high; drives inputs, steps model, checks next negedge
  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      string tag;
      logic [1:0] ps;
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      cond = lfsr[17:16];
      disp = lfsr[23:20];
      ps = m_word[ADDR_W +: 2];
      m_upc  = succ(m_word, m_cq, m_dq);
      m_cq   = cond;
      m_dq   = disp;
      m_word = img[m_upc];
      if (first_after_reset) tag = "R2";
      else case (ps)
        2'd0: tag = "R3";
        2'd1: tag = "R4/R8";
        2'd2: tag = "R5/R8";
        default: tag = "R6/R8";
      endcase
      first_after_reset = 1'b0;
      @(negedge clk);
      chk(tag, 48'(upc), 48'(m_upc));
      chk("R7", 48'(ctrl), 48'(m_word[ADDR_W+2 +: CTRL_W]));
    end
  endtask

  task automatic write_word(int a, logic [WORD_W-1:0] w);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = w;
    img[a] = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cond = '0; disp = '0;
    model_reset();
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) write_word(a, make_word(a));
    chk("R1", 48'(upc), 48'd0);
    chk("R1", 48'(ctrl), 48'd0);
    cond = 2'b11; disp = 4'hF;
    @(negedge clk);
    rst_n = 1'b1;
    run_cycles(4000);

    // asynchronous reset mid-run
    @(posedge clk); #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1", 48'(upc), 48'd0);
    chk("R1", 48'(ctrl), 48'd0);
    @(negedge clk);
    model_reset();
    // rewrite word 0 as a self-loop with a new control field
    write_word(0, {36'hABC_DE12_34, 2'd0, 10'd0});
    chk("R1", 48'(upc), 48'd0);
    rst_n = 1'b1;
    run_cycles(20);
    chk("R10", 48'(upc), 48'd0);
    chk("R9", 48'(ctrl), 48'hA_BCDE_1234);

    // rewrite word 0 to a dispatch with base 16, then resume random trace
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    write_word(0, {36'h5A5_A5A5_A5, 2'd3, 10'd16});
    rst_n = 1'b1;
    run_cycles(600);

    summary();
    $finish;
  end
endmodule